// File: doc/BRIEF.md
# Transmit Start Power-Amplifier Sequencer

This block orders the first microseconds of a frame transmission in a low-rate radio transmitter. While the synthesizer is locked and the transmitter is idle, a one-cycle trigger strobe moves the block into a busy state. From that point a microsecond timebase counts toward a fixed modulation start. Before that start, three enables rise in turn: the internal PA buffer, the internal PA, and a complementary pin pair that switches an external power amplifier. The buffer and the external pair each have their own lead time, chosen by a 2-bit field.

Both lead fields are captured when the trigger is accepted. Once the modulation start point is reached, every enable stays on until a frame-done strobe returns the block to the locked-idle state. A trigger that arrives while the block is busy is ignored. The synthesizer, the modulator and the analog ramp shaping are outside this block.

Top module: `txs_pa_seq`

## Requirements
- R1: During reset and after it, `state_o` is 2'b00 (locked idle), `pa_buf_en_o`, `pa_en_o`, `ext_pa_p_o` and `mod_on_o` are 0, and `ext_pa_n_o` is 1.
- R2: A `trig_i` sampled high at a clock edge while `state_o` is 2'b00 makes `state_o` 2'b01 (ramping) after that edge.
- R3: `state_o` becomes 2'b10 and `mod_on_o` becomes 1 exactly MOD_US × CYC_PER_US cycles (256 by default) after the edge that accepted the trigger. Before that point `mod_on_o` is 0.
- R4: `pa_buf_en_o` rises 2 × (f + 1) µs before modulation start, where f is the value of `buf_lead_i` at the trigger (0→2, 1→4, 2→6, 3→8 µs).
- R5: The external pair reads `ext_pa_p_o`=1 and `ext_pa_n_o`=0 from 2 × (g + 1) µs before modulation start, where g is the value of `ext_lead_i` at the trigger. At all other times it reads 0 and 1.
- R6: `pa_en_o` rises 2 µs before modulation start, whatever the lead fields hold.
- R7: Changes to `buf_lead_i` or `ext_lead_i` after the trigger edge have no effect on the sequence under way.
- R8: A `frame_done_i` sampled high while `state_o` is not 2'b00 returns the block to the R1 output values after that edge. A following trigger then starts a fresh, fully timed sequence.
- R9: A `trig_i` while busy does not restart or shift the sequence. A `frame_done_i` while locked idle changes nothing.
- R10: Once asserted, every enable stays asserted, through modulation, until frame done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Transmit trigger strobe |
| buf_lead_i | input | 2 | PA buffer lead-time code |
| ext_lead_i | input | 2 | External PA pair lead-time code |
| frame_done_i | input | 1 | Frame-done strobe |
| state_o | output | 2 | 00 locked idle, 01 ramping, 10 modulating |
| pa_buf_en_o | output | 1 | Internal PA buffer enable |
| pa_en_o | output | 1 | Internal PA enable |
| ext_pa_p_o | output | 1 | External PA pair, true leg |
| ext_pa_n_o | output | 1 | External PA pair, complement leg |
| mod_on_o | output | 1 | Modulation active |

## Verification
The state code changes one cycle after the accepting edge. An enable with lead L µs is due 16 × (16 − L) cycles after that edge, and modulation is due at cycle 256. Frame done clears everything one cycle after it is sampled. The bench counts edges from the trigger edge and compares every output against a value computed from that count at each falling edge. Each output is therefore judged in the exact cycle it is due: one cycle early or late counts as a failure. Re-triggers, lead-field changes and idle frame-done pulses are applied in the middle of runs, and the run goes on being compared against the same schedule.

// File: rtl/txs_pkg.sv
package txs_pkg;

  typedef enum logic [1:0] {
    TXS_LOCKED = 2'b00,
    TXS_RAMP   = 2'b01,
    TXS_MOD    = 2'b10
  } txs_state_e;

  // microseconds added per step of a lead-time code
  localparam int unsigned LEAD_STEP_US = 2;

endpackage

// File: rtl/txs_usec_tick.sv
module txs_usec_tick #(
  parameter int unsigned CYC_PER_US = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);

  localparam int unsigned PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_PER_US - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          pre_en;

  always_comb begin
    pre_d  = pre_q;
    pre_en = clear_i | run_i;
    if (clear_i) begin
      pre_d = '0;
    end else if (run_i) begin
      pre_d = (pre_q == LAST) ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (pre_en) begin
      pre_q <= pre_d;
    end
  end

  assign tick_o = run_i && !clear_i && (pre_q == LAST);

  // R3: microsecond ticks are spaced by the prescale count
  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (CYC_PER_US > 1)) |=> !tick_o);

endmodule

// File: rtl/txs_ctrl.sv
module txs_ctrl
  import txs_pkg::*;
#(
  parameter int unsigned MOD_US = 16,
  parameter int unsigned US_W   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  logic            done_i,
  input  logic            tick_i,
  output txs_state_e      state_o,
  output logic [US_W-1:0] us_o,
  output logic            start_o
);

  localparam logic [US_W-1:0] US_LAST = US_W'(MOD_US - 1);
  localparam logic [US_W-1:0] US_END  = US_W'(MOD_US);

  txs_state_e      state_q, state_d;
  logic [US_W-1:0] us_q, us_d;
  logic            step_en;

  assign start_o = (state_q == TXS_LOCKED) && trig_i;
  assign step_en = trig_i | done_i | tick_i;

  always_comb begin
    state_d = state_q;
    us_d    = us_q;
    unique case (state_q)
      TXS_LOCKED: begin
        if (trig_i) begin
          state_d = TXS_RAMP;
          us_d    = '0;
        end
      end
      TXS_RAMP: begin
        if (done_i) begin
          state_d = TXS_LOCKED;
          us_d    = '0;
        end else if (tick_i) begin
          if (us_q == US_LAST) begin
            state_d = TXS_MOD;
            us_d    = US_END;
          end else begin
            us_d = us_q + 1'b1;
          end
        end
      end
      TXS_MOD: begin
        if (done_i) begin
          state_d = TXS_LOCKED;
          us_d    = '0;
        end
      end
      default: begin
        state_d = TXS_LOCKED;
        us_d    = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TXS_LOCKED;
      us_q    <= '0;
    end else if (step_en) begin
      state_q <= state_d;
      us_q    <= us_d;
    end
  end

  assign state_o = state_q;
  assign us_o    = us_q;

  // R2: accepted trigger enters ramping with a cleared count
  a_r2_trig_enters_ramp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TXS_LOCKED && trig_i) |=> (state_q == TXS_RAMP && us_q == '0));

  // R8: frame done while busy returns to locked idle
  a_r8_done_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != TXS_LOCKED && done_i) |=> (state_q == TXS_LOCKED));

  // R9: a trigger while ramping neither aborts nor rewinds the count
  a_r9_busy_trig_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TXS_RAMP && trig_i && !done_i) |=>
      (state_q != TXS_LOCKED && us_q >= $past(us_q)));

  // R10: modulation holds until frame done
  a_r10_mod_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TXS_MOD && !done_i) |=> (state_q == TXS_MOD));

endmodule

// File: rtl/txs_lead_gate.sv
module txs_lead_gate
  import txs_pkg::*;
#(
  parameter int unsigned LEAD_W = 2,
  parameter int unsigned MOD_US = 16,
  parameter int unsigned US_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [US_W-1:0]   us_i,
  input  logic [LEAD_W-1:0] code_i,
  output logic              en_o
);

  localparam int unsigned SW = US_W + LEAD_W + 3;

  logic [SW-1:0] lead_us;
  logic [SW-1:0] reach;

  always_comb begin
    lead_us = SW'((SW'(code_i) + SW'(1)) * SW'(LEAD_STEP_US));
    reach   = SW'(us_i) + lead_us;
    en_o    = busy_i && (reach >= SW'(MOD_US));
  end

  // R10: an enable does not drop while the sequence stays busy
  a_r10_no_early_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && busy_i) |=> (en_o || !busy_i));

endmodule

// File: rtl/txs_pa_seq.sv
module txs_pa_seq
  import txs_pkg::*;
#(
  parameter int unsigned CYC_PER_US   = 16,
  parameter int unsigned MOD_US       = 16,
  parameter int unsigned LEAD_W       = 2,
  parameter int unsigned PA_LEAD_CODE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [LEAD_W-1:0] buf_lead_i,
  input  logic [LEAD_W-1:0] ext_lead_i,
  input  logic              frame_done_i,
  output logic [1:0]        state_o,
  output logic              pa_buf_en_o,
  output logic              pa_en_o,
  output logic              ext_pa_p_o,
  output logic              ext_pa_n_o,
  output logic              mod_on_o
);

  localparam int unsigned US_W    = $clog2(MOD_US + 1);
  localparam int unsigned N_GATES = 3;
  localparam int unsigned G_BUF   = 0;
  localparam int unsigned G_PA    = 1;
  localparam int unsigned G_EXT   = 2;

  txs_state_e        state;
  logic [US_W-1:0]   us_cnt;
  logic              start;
  logic              tick;
  logic              busy;
  logic [LEAD_W-1:0] buf_code_q, ext_code_q;
  logic [LEAD_W-1:0] gate_code [N_GATES];
  logic [N_GATES-1:0] gate_en;

  // lead codes are held for the whole sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_code_q <= '0;
      ext_code_q <= '0;
    end else if (start) begin
      buf_code_q <= buf_lead_i;
      ext_code_q <= ext_lead_i;
    end
  end

  txs_usec_tick #(
    .CYC_PER_US(CYC_PER_US)
  ) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(start),
    .run_i  (state == TXS_RAMP),
    .tick_o (tick)
  );

  txs_ctrl #(
    .MOD_US(MOD_US),
    .US_W  (US_W)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .done_i (frame_done_i),
    .tick_i (tick),
    .state_o(state),
    .us_o   (us_cnt),
    .start_o(start)
  );

  assign busy = (state != TXS_LOCKED);

  always_comb begin
    gate_code[G_BUF] = buf_code_q;
    gate_code[G_PA]  = LEAD_W'(PA_LEAD_CODE);
    gate_code[G_EXT] = ext_code_q;
  end

  for (genvar g = 0; g < N_GATES; g++) begin : g_gate
    txs_lead_gate #(
      .LEAD_W(LEAD_W),
      .MOD_US(MOD_US),
      .US_W  (US_W)
    ) u_gate (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .busy_i(busy),
      .us_i  (us_cnt),
      .code_i(gate_code[g]),
      .en_o  (gate_en[g])
    );
  end

  assign state_o     = state;
  assign pa_buf_en_o = gate_en[G_BUF];
  assign pa_en_o     = gate_en[G_PA];
  assign ext_pa_p_o  = gate_en[G_EXT];
  assign ext_pa_n_o  = !gate_en[G_EXT];
  assign mod_on_o    = (state == TXS_MOD);

  // R1: locked idle keeps every enable off and the pair idle
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b00) |-> (!pa_buf_en_o && !pa_en_o && !ext_pa_p_o && ext_pa_n_o && !mod_on_o));

  // R6: the internal PA never leads its buffer
  a_r6_pa_after_buf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pa_en_o |-> pa_buf_en_o);

  // R3: modulation only with every amplifier stage enabled
  a_r3_mod_needs_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_on_o |-> (pa_buf_en_o && pa_en_o && ext_pa_p_o && !ext_pa_n_o));

  // R7: captured codes hold steady while busy
  a_r7_codes_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !frame_done_i) |=> ($stable(buf_code_q) && $stable(ext_code_q)));

endmodule

// File: tb/sim_txs_pa_seq.sv
`timescale 1ns/1ps
module sim_txs_pa_seq;

  localparam int CYC = 16;
  localparam int MODU = 16;
  localparam int MOD_CYC = CYC * MODU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic [1:0] bl = 2'b00;
  logic [1:0] el = 2'b00;
  logic done = 1'b0;
  logic [1:0] st;
  logic buf_en, pa_en, xp, xn, mod_on;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  txs_pa_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .buf_lead_i(bl),
    .ext_lead_i(el), .frame_done_i(done), .state_o(st),
    .pa_buf_en_o(buf_en), .pa_en_o(pa_en), .ext_pa_p_o(xp),
    .ext_pa_n_o(xn), .mod_on_o(mod_on)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " state"}, st, 0);
    chk({req, " buf"}, buf_en, 0);
    chk({req, " pa"}, pa_en, 0);
    chk({req, " pair_p"}, xp, 0);
    chk({req, " pair_n"}, xn, 1);
    chk({req, " mod"}, mod_on, 0);
  endtask

  // R1: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle("R1 after reset");
  endtask

  // R2 R3 R4 R5 R6 R7 R8 R9 R10: one full sequence, checked every cycle
  task automatic t_sequence(input logic [1:0] bf, input logic [1:0] ef,
                            input int retrig_k, input int done_k);
    int us, lb, le;
    lb = 2 * (bf + 1);
    le = 2 * (ef + 1);
    trig = 1'b1; bl = bf; el = ef;
    @(negedge clk);
    trig = 1'b0;
    bl = ~bf; el = ~ef;  // R7: fields change after the trigger edge
    for (int k = 0; k <= done_k; k++) begin
      us = (k / CYC > MODU) ? MODU : k / CYC;
      chk("R2 R3 state", st, (k >= MOD_CYC) ? 2 : 1);
      chk("R3 mod", mod_on, (k >= MOD_CYC) ? 1 : 0);
      chk("R4 R7 buf", buf_en, (us + lb >= MODU) ? 1 : 0);
      chk("R6 pa", pa_en, (us + 2 >= MODU) ? 1 : 0);
      chk("R5 R7 pair_p", xp, (us + le >= MODU) ? 1 : 0);
      chk("R5 pair_n", xn, (us + le >= MODU) ? 0 : 1);
      trig = (k == retrig_k);   // R9: busy trigger
      done = (k == done_k);
      @(negedge clk);
    end
    trig = 1'b0;
    done = 1'b0;
    chk_idle("R8 after done");
  endtask

  // R9: frame done while idle changes nothing
  task automatic t_idle_done();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk_idle("R9 idle done");
    repeat (5) @(negedge clk);
    chk_idle("R9 idle hold");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence(2'd0, 2'd3, -1, MOD_CYC + 20);
    t_sequence(2'd3, 2'd0, 100, MOD_CYC + 5);
    t_sequence(2'd1, 2'd2, MOD_CYC + 2, MOD_CYC + 8);
    t_sequence(2'd2, 2'd1, -1, 60);            // R8: early abort
    t_sequence(2'd2, 2'd1, 150, MOD_CYC + 3);  // R8: clean restart
    t_idle_done();
    t_sequence(2'd3, 2'd3, 0, MOD_CYC);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule